// File: doc/BRIEF.md
# Primitive Topology Index Converter

This streaming block rewrites a vertex index stream whose topology a downstream rasterizer cannot draw into one it can. A draw starts with a command that names a topology, an index count, and an optional reset marker value. The block then takes exactly that many indices on a valid/ready input and produces the converted indices on a valid/ready output. It supports three conversions. Triangle fans become triangle lists. Line loops become line strips. Quad lists become triangle lists. A fourth topology code consumes its indices and produces nothing.

When reset markers are enabled, every index equal to the marker value ends the current primitive. Each run between markers is converted as a separate primitive, and the markers themselves never appear on the output. When the command is accepted, the block registers an upper bound on the number of indices the draw can emit. This bound is exact when markers are disabled. Indices arrive already in host byte order. The block holds only the first index, the previous index and the quad corners, never a whole primitive.

Top module: `topo_index_conv`

## Requirements
- R1: Topology code 0 (fan): for a primitive of n indices with n > 2, each index from the third onward emits the triangle (previous index, current index, first index), giving (n-2)*3 outputs. A primitive of 2 or fewer indices emits nothing.
- R2: Topology code 1 (loop): a primitive of n > 1 indices emits all n in input order followed by the first index again, giving n+1 outputs. A primitive of one index emits nothing.
- R3: Topology code 2 (quad): each complete group of four indices a,b,c,d emits a,b,c,a,c,d. Indices left over after the last complete group of a primitive are dropped.
- R4: With `cmd_rst_en` set, an index equal to `cmd_rst_idx` over all 32 bits closes the current primitive and starts a new one. The marker is never emitted, and a loop closed by a marker still emits its closing index.
- R5: With `cmd_rst_en` clear, an index equal to `cmd_rst_idx` is treated as an ordinary vertex.
- R6: On command acceptance, `hdr_max_count` is loaded with (n-2)*3 for a fan with n > 2, n+1 for a loop with n > 1, (n/4)*6 for a quad, and 0 otherwise. Topology code 3 consumes its indices and emits nothing. The number of indices a draw emits never exceeds this value.
- R7: `out_idx` and `out_valid` hold steady while `out_ready` is low. A command is accepted only when the previous draw has fully drained (`cmd_ready` high), and `in_ready` stays low outside a draw.
- R8: With `out_ready` held high and input supplied without gaps, a fan produces one output every cycle from its first output to its last. A new index is accepted in the same cycle that the last pending output of the previous index leaves.
- R9: Synchronous reset, active high, empties the block at any point. After reset, `cmd_ready` is 1, `in_ready` is 0, `out_valid` is 0 and `hdr_max_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Draw command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_topo | input | 2 | 0 fan, 1 loop, 2 quad, 3 discard |
| cmd_count | input | 16 | Number of input indices in the draw |
| cmd_rst_en | input | 1 | Enable reset-marker splitting |
| cmd_rst_idx | input | 32 | Reset marker value |
| hdr_max_count | output | 18 | Output-count bound latched at command acceptance |
| in_valid | input | 1 | Input index offered |
| in_ready | output | 1 | Input index accepted this cycle |
| in_idx | input | 32 | Input vertex index |
| out_valid | output | 1 | Converted index offered |
| out_ready | input | 1 | Downstream takes the converted index |
| out_idx | output | 32 | Converted vertex index |

## Verification
Two events can fall in the same cycle: the last queued output of one input index leaves the block, and the next input index is accepted and reloads the same emission slots. The bench provokes this with a six-index fan while `out_ready` is held high and input is offered continuously. It judges the result in two ways. The recorded outputs must be correct in value and order, and the clock distance between the first and the last output must equal the output count minus one. Tests with backpressure, where `out_ready` drops one cycle in three, put the same collision at shifting phases.

// File: rtl/topo_pkg.sv
package topo_pkg;

    typedef enum logic [1:0] {
        TOPO_FAN  = 2'd0,
        TOPO_LOOP = 2'd1,
        TOPO_QUAD = 2'd2,
        TOPO_DROP = 2'd3
    } topo_e;

    typedef struct packed {
        topo_e topo;
        logic  rst_en;
    } draw_mode_t;

    // Largest burst one input index can produce (a closed quad).
    localparam int EMIT_MAX   = 6;
    localparam int EMIT_CNT_W = $clog2(EMIT_MAX + 1);

    function automatic int unsigned bound_count(topo_e t, int unsigned n);
        unique case (t)
            TOPO_FAN:  return (n > 2) ? (n - 2) * 3 : 0;
            TOPO_LOOP: return (n > 1) ? n + 1 : 0;
            TOPO_QUAD: return (n / 4) * 6;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/topo_seq.sv
module topo_seq
    import topo_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             take,
    input  logic             is_last,
    input  draw_mode_t       mode,
    input  logic [IDX_W-1:0] rst_val,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] list_o [EMIT_MAX],
    output logic [EMIT_CNT_W-1:0] list_n
);

    // pos: indices seen in the current primitive (saturates at 2 for fan
    // and loop, wraps modulo 4 for quad).
    logic [1:0]       pos, pos_nx;
    logic [IDX_W-1:0] first, first_nx;
    logic [IDX_W-1:0] prev, prev_nx;
    logic [IDX_W-1:0] qb, qb_nx;
    logic [IDX_W-1:0] qc, qc_nx;
    logic             seg_break;

    assign seg_break = mode.rst_en && (idx == rst_val);

    always_comb begin
        for (int k = 0; k < EMIT_MAX; k++) list_o[k] = '0;
        list_n   = '0;
        pos_nx   = pos;
        first_nx = first;
        prev_nx  = prev;
        qb_nx    = qb;
        qc_nx    = qc;
        if (seg_break) begin
            pos_nx = 2'd0;
            if (mode.topo == TOPO_LOOP && pos == 2'd2) begin
                list_o[0] = first;
                list_n    = EMIT_CNT_W'(1);
            end
        end else begin
            unique case (mode.topo)
                TOPO_FAN: begin
                    if (pos == 2'd0) begin
                        first_nx = idx;
                        pos_nx   = 2'd1;
                    end else if (pos == 2'd1) begin
                        prev_nx = idx;
                        pos_nx  = 2'd2;
                    end else begin
                        list_o[0] = prev;
                        list_o[1] = idx;
                        list_o[2] = first;
                        list_n    = EMIT_CNT_W'(3);
                        prev_nx   = idx;
                    end
                end
                TOPO_LOOP: begin
                    if (pos == 2'd0) begin
                        first_nx = idx;
                        pos_nx   = 2'd1;
                    end else if (pos == 2'd1) begin
                        list_o[0] = first;
                        list_o[1] = idx;
                        list_o[2] = first;
                        list_n    = is_last ? EMIT_CNT_W'(3) : EMIT_CNT_W'(2);
                        pos_nx    = 2'd2;
                    end else begin
                        list_o[0] = idx;
                        list_o[1] = first;
                        list_n    = is_last ? EMIT_CNT_W'(2) : EMIT_CNT_W'(1);
                    end
                end
                TOPO_QUAD: begin
                    pos_nx = pos + 2'd1;
                    if (pos == 2'd0) first_nx = idx;
                    else if (pos == 2'd1) qb_nx = idx;
                    else if (pos == 2'd2) qc_nx = idx;
                    else begin
                        list_o[0] = first;
                        list_o[1] = qb;
                        list_o[2] = qc;
                        list_o[3] = first;
                        list_o[4] = qc;
                        list_o[5] = idx;
                        list_n    = EMIT_CNT_W'(6);
                    end
                end
                default: begin
                    pos_nx = 2'd0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            first <= '0;
            prev  <= '0;
            qb    <= '0;
            qc    <= '0;
        end else if (start) begin
            pos <= '0;
        end else if (take) begin
            pos   <= pos_nx;
            first <= first_nx;
            prev  <= prev_nx;
            qb    <= qb_nx;
            qc    <= qc_nx;
        end
    end

endmodule

// File: rtl/topo_emit_buf.sv
module topo_emit_buf
    import topo_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [IDX_W-1:0]      load_list [EMIT_MAX],
    input  logic [EMIT_CNT_W-1:0] load_n,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [IDX_W-1:0]      out_idx,
    output logic                  empty,
    output logic                  drain_last
);

    logic [IDX_W-1:0]      slot [EMIT_MAX];
    logic [EMIT_CNT_W-1:0] cnt;
    logic [EMIT_CNT_W-1:0] rd;
    logic                  fire;

    assign out_valid  = (rd != cnt);
    assign empty      = !out_valid;
    assign fire       = out_valid && out_ready;
    assign drain_last = fire && (rd + EMIT_CNT_W'(1) == cnt);
    assign out_idx    = slot[rd];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rd  <= '0;
            for (int k = 0; k < EMIT_MAX; k++) slot[k] <= '0;
        end else if (load) begin
            for (int k = 0; k < EMIT_MAX; k++) slot[k] <= load_list[k];
            cnt <= load_n;
            rd  <= '0;
        end else if (fire) begin
            rd <= rd + EMIT_CNT_W'(1);
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_idx)); // R7

    AST_LOAD_ROOM: assert property (@(posedge clk) disable iff (rst)
        load |-> (empty || drain_last)); // R8

endmodule

// File: rtl/topo_index_conv.sv
module topo_index_conv
    import topo_pkg::*;
#(
    parameter int IDX_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_topo,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic                 cmd_rst_en,
    input  logic [IDX_W-1:0]     cmd_rst_idx,
    output logic [CNT_W+1:0]     hdr_max_count,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [IDX_W-1:0]     in_idx,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [IDX_W-1:0]     out_idx
);

    localparam int OUT_CNT_W = CNT_W + 2;

    logic                  busy;
    logic [CNT_W-1:0]      remaining;
    draw_mode_t            mode;
    logic [IDX_W-1:0]      rst_val;
    logic                  start, take, is_last;
    logic                  buf_empty, buf_drain_last;
    logic [IDX_W-1:0]      list [EMIT_MAX];
    logic [EMIT_CNT_W-1:0] list_n;

    assign cmd_ready = !busy;
    assign start     = cmd_valid && cmd_ready;
    assign in_ready  = busy && (remaining != '0) && (buf_empty || buf_drain_last);
    assign take      = in_valid && in_ready;
    assign is_last   = (remaining == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            remaining     <= '0;
            mode          <= '{topo: TOPO_FAN, rst_en: 1'b0};
            rst_val       <= '0;
            hdr_max_count <= '0;
        end else if (start) begin
            busy          <= (cmd_count != '0);
            remaining     <= cmd_count;
            mode          <= '{topo: topo_e'(cmd_topo), rst_en: cmd_rst_en};
            rst_val       <= cmd_rst_idx;
            hdr_max_count <= OUT_CNT_W'(bound_count(topo_e'(cmd_topo), 32'(cmd_count)));
        end else begin
            if (take) remaining <= remaining - CNT_W'(1);
            if (busy && remaining == '0 && buf_empty) busy <= 1'b0;
        end
    end

    topo_seq #(.IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .take    (take),
        .is_last (is_last),
        .mode    (mode),
        .rst_val (rst_val),
        .idx     (in_idx),
        .list_o  (list),
        .list_n  (list_n)
    );

    topo_emit_buf #(.IDX_W(IDX_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .load       (take),
        .load_list  (list),
        .load_n     (list_n),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_idx    (out_idx),
        .empty      (buf_empty),
        .drain_last (buf_drain_last)
    );

    // Emitted-index tally of the current draw, used by the bound check.
    logic [OUT_CNT_W-1:0] emitted;
    always_ff @(posedge clk) begin
        if (rst || start) emitted <= '0;
        else if (out_valid && out_ready) emitted <= emitted + OUT_CNT_W'(1);
    end

    AST_EMIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        !start |-> emitted <= hdr_max_count); // R6

    AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !out_valid); // R7

    AST_IDLE_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !in_ready); // R7

endmodule

// File: tb/topo_index_conv_tb.sv
`timescale 1ns/1ps
module topo_index_conv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_topo = 2'd0;
    logic [15:0] cmd_count = '0;
    logic        cmd_rst_en = 1'b0;
    logic [31:0] cmd_rst_idx = '0;
    logic [17:0] hdr_max_count;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_idx = '0;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_idx;

    always #2.5 clk = ~clk;

    topo_index_conv u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_topo(cmd_topo),
        .cmd_count(cmd_count), .cmd_rst_en(cmd_rst_en), .cmd_rst_idx(cmd_rst_idx),
        .hdr_max_count(hdr_max_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Output collector with optional backpressure
    logic        coll_en  = 1'b0;
    logic        bp       = 1'b0;
    logic        hold_off = 1'b0;
    int          cyc = 0;
    int          got_n = 0;
    logic [31:0] got [32];
    int          got_cyc [32];

    initial out_ready = 1'b1;
    always @(negedge clk) begin
        cyc++;
        out_ready = hold_off ? 1'b0 : (bp ? (cyc % 3 != 1) : 1'b1);
        #1;
        if (coll_en && out_valid && out_ready) begin
            if (got_n < 32) begin
                got[got_n]     = out_idx;
                got_cyc[got_n] = cyc;
            end
            got_n++;
        end
    end

    // Stimulus table: inputs and expected outputs are 4-bit values packed
    // with element 0 in the lowest nibble. Reset marker is 4'hF.
    typedef struct packed {
        logic [1:0]  topo;
        logic        rst_en;
        logic [3:0]  rst_nib;
        logic [3:0]  n;
        logic [31:0] in_w;
        logic [4:0]  exp_n;
        logic [7:0]  exp_max;
        logic [47:0] exp_w;
        logic        bp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 4'hF, 4'd5, 32'h00054321, 5'd9,  8'd9,  48'h000154143132, 1'b0}, // R1 fan
        '{2'd1, 1'b0, 4'hF, 4'd4, 32'h00009876, 5'd5,  8'd5,  48'h000000069876, 1'b1}, // R2 loop
        '{2'd2, 1'b0, 4'hF, 4'd6, 32'h00654321, 5'd6,  8'd6,  48'h000000431321, 1'b0}, // R3 quad tail dropped
        '{2'd0, 1'b1, 4'hF, 4'd8, 32'h7654F321, 5'd9,  8'd18, 48'h000476465132, 1'b1}, // R4 fan split
        '{2'd1, 1'b1, 4'hF, 4'd7, 32'h054F3F21, 5'd6,  8'd8,  48'h000000454121, 1'b0}, // R4 loop split
        '{2'd1, 1'b0, 4'hF, 4'd1, 32'h00000003, 5'd0,  8'd0,  48'h0,            1'b0}, // R2 single
        '{2'd0, 1'b0, 4'hF, 4'd2, 32'h00000021, 5'd0,  8'd0,  48'h0,            1'b0}, // R1 short
        '{2'd1, 1'b0, 4'hF, 4'd2, 32'h00000065, 5'd3,  8'd3,  48'h000000000565, 1'b1}, // R2 pair
        '{2'd2, 1'b1, 4'hF, 4'd8, 32'h7654F321, 5'd6,  8'd12, 48'h000000764654, 1'b1}, // R4 quad split
        '{2'd3, 1'b0, 4'hF, 4'd3, 32'h00000321, 5'd0,  8'd0,  48'h0,            1'b0}, // R6 discard
        '{2'd0, 1'b0, 4'hF, 4'd3, 32'h0000021F, 5'd3,  8'd3,  48'h000000000F21, 1'b0}, // R5 marker off
        '{2'd2, 1'b0, 4'hF, 4'd8, 32'h87654321, 5'd12, 8'd12, 48'h875765431321, 1'b1}  // R3 two quads
    };

    function automatic string req_of(int i);
        case (i)
            0, 6:       return "R1";
            1, 5, 7:    return "R2";
            2, 11:      return "R3";
            3, 4, 8:    return "R4";
            10:         return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic issue_cmd(input logic [1:0] t, input logic re,
                             input logic [31:0] rv, input logic [15:0] n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_topo = t; cmd_rst_en = re;
        cmd_rst_idx = rv; cmd_count = n;
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic feed_idx(input logic [31:0] v);
        in_valid = 1'b1;
        in_idx   = v;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
    endtask

    task automatic wait_idle();
        #1;
        while (!cmd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        v = VECS[i];
        bp = v.bp; got_n = 0; coll_en = 1'b1;
        issue_cmd(v.topo, v.rst_en, {28'd0, v.rst_nib}, {12'd0, v.n});
        chk(hdr_max_count == {10'd0, v.exp_max}, "R6", $sformatf("vec %0d bound", i),
            32'(hdr_max_count), {24'd0, v.exp_max});
        for (int k = 0; k < int'(v.n); k++) feed_idx({28'd0, v.in_w[k*4 +: 4]});
        in_valid = 1'b0;
        wait_idle();
        coll_en = 1'b0;
        chk(got_n == int'(v.exp_n), req_of(i), $sformatf("vec %0d count", i),
            32'(got_n), {27'd0, v.exp_n});
        for (int k = 0; k < int'(v.exp_n); k++)
            chk(got[k] == {28'd0, v.exp_w[k*4 +: 4]}, req_of(i),
                $sformatf("vec %0d out %0d", i, k), got[k], {28'd0, v.exp_w[k*4 +: 4]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk(cmd_ready == 1'b1, "R9", "cmd_ready after reset", 32'(cmd_ready), 1);
        chk(in_ready == 1'b0, "R9", "in_ready after reset", 32'(in_ready), 0);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 0);
        chk(hdr_max_count == '0, "R9", "bound after reset", 32'(hdr_max_count), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R8 fan throughput: 6 indices -> 12 outputs, no gap
        bp = 1'b0; got_n = 0; coll_en = 1'b1;
        issue_cmd(2'd0, 1'b0, 32'hFFFF_FFFF, 16'd6);
        for (int k = 1; k <= 6; k++) feed_idx(32'(k));
        in_valid = 1'b0;
        wait_idle();
        coll_en = 1'b0;
        chk(got_n == 12, "R8", "burst count", 32'(got_n), 12);
        chk(got_cyc[11] - got_cyc[0] == 11, "R8", "burst span cycles",
            32'(got_cyc[11] - got_cyc[0]), 11);
        chk(got[9] == 32'd5 && got[10] == 32'd6 && got[11] == 32'd1, "R8", "burst tail",
            got[10], 32'd6);

        // R7 stall: outputs hold while out_ready low
        hold_off = 1'b1; got_n = 0; coll_en = 1'b1;
        issue_cmd(2'd0, 1'b0, 32'h0, 16'd3);
        feed_idx(32'hA1); feed_idx(32'hA2); feed_idx(32'hA3);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(out_valid && out_idx == 32'hA2, "R7", "stalled output held", out_idx, 32'hA2);
            chk(cmd_ready == 1'b0, "R7", "no command while draining", 32'(cmd_ready), 0);
        end
        hold_off = 1'b0;
        wait_idle();
        coll_en = 1'b0;
        chk(got_n == 3 && got[0] == 32'hA2 && got[1] == 32'hA3 && got[2] == 32'hA1,
            "R7", "stalled triangle", got[2], 32'hA1);

        // R6 zero-count command returns idle at once
        issue_cmd(2'd1, 1'b0, 32'h0, 16'd0);
        #1;
        chk(cmd_ready == 1'b1 && hdr_max_count == '0, "R6", "empty draw",
            32'(hdr_max_count), 0);

        // R9 reset mid-draw
        hold_off = 1'b1;
        issue_cmd(2'd0, 1'b0, 32'h0, 16'd5);
        feed_idx(32'd1); feed_idx(32'd2); feed_idx(32'd3);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        hold_off = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9", "out_valid after mid reset", 32'(out_valid), 0);
        chk(cmd_ready == 1'b1, "R9", "cmd_ready after mid reset", 32'(cmd_ready), 1);
        chk(in_ready == 1'b0, "R9", "in_ready after mid reset", 32'(in_ready), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule